// File: doc/BRIEF.md
# Scanning ADC Acquisition Sequencer

This block runs the conversion side of a multichannel acquisition front end. Software programs a first and a last channel number and picks a trigger source. Each accepted trigger issues one convert-start pulse, with the current channel on the channel-select output. When the converter answers with its done strobe, the sample is pushed into a sample FIFO and the scan pointer moves to the next channel. After the last channel, the pointer returns to the first.

Four word registers sit on a simple register bus. A data port writes the software trigger and reads by popping the FIFO. A mux register holds the scan bounds. A control register holds the trigger source and the differential flag. A status register holds the FIFO flags, the overflow flag and the busy flag, and a write to it clears the overflow. The converter itself is modelled as a done/data handshake. Converter words narrower than 16 bits are stored left-justified.

Top module: `adc_scan_seq`

## Requirements
- R1: The register at address 1 holds the first scan channel in bits 5:0 and the last scan channel in bits 13:8. It reads back in that layout, with zeros in the other bits. A write to it also loads the scan pointer with the new first channel.
- R2: Each converter-done that completes a pending conversion advances the scan pointer by one. If the pointer was at or above the last channel, it returns to the first channel instead. When first equals last, one channel is sampled repeatedly. The pointer does not change otherwise.
- R3: Control register (address 2) bits 1:0 choose the trigger. Code 0 is a write to address 0. Code 1 is a falling edge of `ext_trig_i`. Code 2 is a rising edge of `ext_trig_i`. Code 3 is a cycle with `pacer_tick_i` high. Sources that are not selected have no effect. The control register reads back with bit 2 as the differential flag.
- R4: An accepted trigger makes `conv_start_o` high for exactly the next cycle and marks a conversion pending. A trigger that arrives while a conversion is pending is ignored. A converter-done that arrives while nothing is pending is ignored.
- R5: Samples leave the FIFO in arrival order. Reading address 0 returns the oldest entry and removes it. Reading address 0 while the FIFO is empty returns the last value removed (0 after reset) and changes nothing.
- R6: Status (address 3) bits are as follows. Bit 0 is FIFO not empty. Bit 1 is at least half of `FIFO_DEPTH` entries. Bit 2 is full. Bit 3 is overflow. Bit 4 is a conversion pending. All other bits are 0.
- R7: A sample that completes while the FIFO is full is dropped and sets the sticky overflow bit. A status write with bit 0 set clears the overflow bit.
- R8: When the differential flag (control bit 2) is set, `chan_sel_o` never exceeds `NUM_CH/2`. A scan pointer above that value is clamped to it.
- R9: With `ADC_BITS` below 16, the converter word's low `ADC_BITS` bits are stored in the upper bits of the 16-bit sample, with zeros below them.
- R10: After reset, the following hold. The FIFO is empty with a last value of 0. Both scan bounds and the pointer are 0. The software trigger is selected, and the differential flag is clear. No conversion is pending, and overflow is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (pops the FIFO at address 0) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| ext_trig_i | input | 1 | External trigger level |
| pacer_tick_i | input | 1 | Pacer timer tick |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 16 | Converter result, right-justified |
| conv_start_o | output | 1 | One-cycle convert-start pulse |
| chan_sel_o | output | 6 | Channel presented to the converter |

## Verification
The scan is driven in four ways. Software writes across a range of four channels show the wrap from last channel to first. Equal bounds show that one channel repeats. The two external edge polarities are tried with slow pulses, so that a wrong polarity shows up as a shifted start cycle. A held pacer tick keeps retriggering and fills the FIFO past full, which separates the dropping of samples from the setting of the overflow bit. Back-to-back triggers and a stray done strobe show that only one conversion is pending at a time. A scan range above half the channel count with the differential flag set shows the clamp, and clearing the flag shows that the clamp depends on it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CH_W   = 6;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_FALL = 2'd1,
    TRG_RISE = 2'd2,
    TRG_TICK = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_MUX  = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_addr_e;

  localparam int unsigned CTL_DIFF_BIT = 2;
  localparam int unsigned CLR_OVF_BIT  = 0;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  trig_src_e src_i,
  input  logic      soft_i,
  input  logic      ext_i,
  input  logic      tick_i,
  output logic      fire_o
);
  logic ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= ext_i;
  end

  always_comb begin
    unique case (src_i)
      TRG_SOFT: fire_o = soft_i;
      TRG_FALL: fire_o = ext_q & ~ext_i;
      TRG_RISE: fire_o = ~ext_q & ext_i;
      TRG_TICK: fire_o = tick_i;
      default:  fire_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            done_i,
  input  logic            load_i,
  input  logic [CH_W-1:0] load_ch_i,
  input  logic [CH_W-1:0] lo_i,
  input  logic [CH_W-1:0] hi_i,
  input  logic            diff_i,
  output logic            busy_o,
  output logic            start_o,
  output logic [CH_W-1:0] ptr_o,
  output logic [CH_W-1:0] chan_sel_o
);
  localparam logic [CH_W-1:0] DIFF_MAX = CH_W'(NUM_CH / 2);

  logic            busy_q, start_q;
  logic [CH_W-1:0] ptr_q;
  logic            done_ok;

  assign done_ok = busy_q & done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      start_q <= fire_i & ~busy_q;
      busy_q  <= busy_q ? ~done_i : fire_i;
      if (load_i)       ptr_q <= load_ch_i;
      else if (done_ok) ptr_q <= (ptr_q >= hi_i) ? lo_i : ptr_q + 1'b1;
    end
  end

  assign busy_o     = busy_q;
  assign start_o    = start_q;
  assign ptr_o      = ptr_q;
  assign chan_sel_o = (diff_i && ptr_q > DIFF_MAX) ? DIFF_MAX : ptr_q;
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          half_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign half_o  = (cnt_q >= CW'(DEPTH / 2));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;
  assign rdata_o = empty_o ? last_q : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop) begin
        rd_q   <= inc(rd_q);
        last_q <= mem_q[rd_q];
      end
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 64,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned ADC_BITS   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic        bus_re_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        ext_trig_i,
  input  logic        pacer_tick_i,
  input  logic        conv_done_i,
  input  logic [15:0] conv_data_i,
  output logic        conv_start_o,
  output logic [5:0]  chan_sel_o
);
  localparam int unsigned PAD = DATA_W - ADC_BITS;

  reg_addr_e       addr;
  logic [CH_W-1:0] lo_q, hi_q, scan_ptr;
  trig_src_e       trig_q;
  logic            diff_q, ovf_q;
  logic            soft_we, mux_we, ctrl_we, stat_we, ovf_clr, pop;
  logic            fire, scan_busy, push;
  logic            fifo_empty, fifo_half, fifo_full, fifo_drop;
  logic [DATA_W-1:0] fifo_rdata, sample;
  logic            unused_wd;

  assign addr    = reg_addr_e'(bus_addr_i);
  assign soft_we = bus_we_i && addr == REG_DATA;
  assign mux_we  = bus_we_i && addr == REG_MUX;
  assign ctrl_we = bus_we_i && addr == REG_CTRL;
  assign stat_we = bus_we_i && addr == REG_STAT;
  assign ovf_clr = stat_we && bus_wdata_i[CLR_OVF_BIT];
  assign pop     = bus_re_i && addr == REG_DATA;
  assign push    = conv_done_i & scan_busy;
  assign unused_wd = ^{bus_wdata_i[15:14], bus_wdata_i[7:6]};

  generate
    if (ADC_BITS >= DATA_W) begin : g_full
      assign sample = conv_data_i;
    end else begin : g_left
      logic unused_hi;
      assign unused_hi = ^conv_data_i[DATA_W-1:ADC_BITS];
      assign sample    = {conv_data_i[ADC_BITS-1:0], {PAD{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      trig_q <= TRG_SOFT;
      diff_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (mux_we) begin
        lo_q <= bus_wdata_i[5:0];
        hi_q <= bus_wdata_i[13:8];
      end
      if (ctrl_we) begin
        trig_q <= trig_src_e'(bus_wdata_i[1:0]);
        diff_q <= bus_wdata_i[CTL_DIFF_BIT];
      end
      if (fifo_drop)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  adc_seq_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (trig_q),
    .soft_i (soft_we),
    .ext_i  (ext_trig_i),
    .tick_i (pacer_tick_i),
    .fire_o (fire)
  );

  adc_seq_scan #(.NUM_CH(NUM_CH)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .done_i     (conv_done_i),
    .load_i     (mux_we),
    .load_ch_i  (bus_wdata_i[5:0]),
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .diff_i     (diff_q),
    .busy_o     (scan_busy),
    .start_o    (conv_start_o),
    .ptr_o      (scan_ptr),
    .chan_sel_o (chan_sel_o)
  );

  adc_seq_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (sample),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .half_o  (fifo_half),
    .full_o  (fifo_full),
    .drop_o  (fifo_drop)
  );

  always_comb begin
    unique case (addr)
      REG_DATA: bus_rdata_o = fifo_rdata;
      REG_MUX:  bus_rdata_o = {2'b00, hi_q, 2'b00, lo_q};
      REG_CTRL: bus_rdata_o = {13'd0, diff_q, trig_q};
      REG_STAT: bus_rdata_o = {11'd0, scan_busy, ovf_q, fifo_full, fifo_half, ~fifo_empty};
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int unsigned NUM_CH = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_start_o,
  input logic       conv_done_i,
  input logic       busy_i,
  input logic [5:0] ptr_i,
  input logic       mux_we_i,
  input logic       ovf_i,
  input logic       ovf_clr_i,
  input logic       diff_i,
  input logic [5:0] chan_sel_o,
  input logic       full_i,
  input logic       pop_i
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R4
  AST_START_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_i); // R4
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !mux_we_i) |=> $stable(ptr_i)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !ovf_clr_i) |=> ovf_i); // R7
  AST_DIFF_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_i |-> (32'(chan_sel_o) <= NUM_CH / 2)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_i && !pop_i) |=> full_i); // R6
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_o (conv_start_o),
  .conv_done_i  (conv_done_i),
  .busy_i       (scan_busy),
  .ptr_i        (scan_ptr),
  .mux_we_i     (mux_we),
  .ovf_i        (ovf_q),
  .ovf_clr_i    (ovf_clr),
  .diff_i       (diff_q),
  .chan_sel_o   (chan_sel_o),
  .full_i       (fifo_full),
  .pop_i        (pop)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int DEPTH = 16;
  localparam int NCH   = 64;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext = 1'b0, tick = 1'b0;
  logic        cvt_done = 1'b0, spur_done = 1'b0;
  logic [15:0] cvt_data = '0;
  logic        conv_done;
  logic        conv_start;
  logic [5:0]  chan_sel;

  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;

  assign conv_done = cvt_done | spur_done;
  always #10 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NCH), .FIFO_DEPTH(DEPTH), .ADC_BITS(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_trig_i(ext), .pacer_tick_i(tick),
    .conv_done_i(conv_done), .conv_data_i(cvt_data), .conv_start_o(conv_start),
    .chan_sel_o(chan_sel));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // converter stand-in
  int cnt = 0;
  int next_val = 1;
  int chlog[$];
  always @(posedge clk) begin
    #1;
    cvt_done = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        cvt_done = 1'b1;
        cvt_data = 16'(next_val & 12'hFFF);
        next_val = next_val + 7;
      end
    end
    if (conv_start) begin
      cnt = LAT;
      chlog.push_back(int'(chan_sel));
    end
  end

  // reference model
  logic [15:0] q[$];
  logic [15:0] m_last;
  int  m_lo, m_hi, m_ptr, m_sel;
  bit  m_diff, m_busy, m_ovf, m_start, m_prev, m_trig;
  int  m_osz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_last = '0; m_lo = 0; m_hi = 0; m_ptr = 0; m_sel = 0;
      m_diff = 0; m_busy = 0; m_ovf = 0; m_start = 0; m_prev = 0;
    end else begin
      case (m_sel)
        0: m_trig = we && addr == 2'd0;
        1: m_trig = m_prev && !ext;
        2: m_trig = !m_prev && ext;
        default: m_trig = tick;
      endcase
      m_osz = q.size();
      m_start = m_trig && !m_busy;
      if (re && addr == 2'd0 && m_osz > 0) m_last = q.pop_front();
      if (we && addr == 2'd3 && wdata[0]) m_ovf = 0;
      if (m_busy && conv_done) begin
        if (m_osz < DEPTH) q.push_back({cvt_data[11:0], 4'h0});
        else m_ovf = 1;
      end
      if (we && addr == 2'd1) m_ptr = int'(wdata[5:0]);
      else if (m_busy && conv_done) m_ptr = (m_ptr >= m_hi) ? m_lo : m_ptr + 1;
      if (m_busy) begin
        if (conv_done) m_busy = 0;
      end else if (m_trig) m_busy = 1;
      if (we && addr == 2'd1) begin m_lo = int'(wdata[5:0]); m_hi = int'(wdata[13:8]); end
      if (we && addr == 2'd2) begin m_sel = int'(wdata[1:0]); m_diff = wdata[2]; end
      m_prev = ext;
    end
  end

  logic [15:0] e_rd;
  int e_ch;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(conv_start == m_start, "R4 conv_start", 16'(conv_start), 16'(m_start));
      e_ch = (m_diff && m_ptr > NCH / 2) ? NCH / 2 : m_ptr;
      chk(int'(chan_sel) == e_ch, m_diff ? "R8 chan_sel" : "R2 chan_sel", 16'(chan_sel), 16'(e_ch));
      case (addr)
        2'd0: e_rd = (q.size() > 0) ? q[0] : m_last;
        2'd1: e_rd = {2'b00, 6'(m_hi), 2'b00, 6'(m_lo)};
        2'd2: e_rd = {13'd0, m_diff, 2'(m_sel)};
        default: e_rd = {11'd0, m_busy, m_ovf, q.size() == DEPTH, q.size() >= DEPTH / 2, q.size() > 0};
      endcase
      case (addr)
        2'd0: chk(rdata == e_rd, "R5 data port", rdata, e_rd);
        2'd1: chk(rdata == e_rd, "R1 mux reg", rdata, e_rd);
        2'd2: chk(rdata == e_rd, "R3 ctrl reg", rdata, e_rd);
        default: chk(rdata == e_rd, "R6 status", rdata, e_rd);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1; re = 1'b1; addr = a;
    @(negedge clk); v = rdata;
    @(posedge clk); #1; re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog act=%h exp=%h", 16'h0, 16'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk(conv_start == 1'b0 && chan_sel == 6'd0, "R10 outputs", {10'd0, chan_sel}, 16'h0);
    rd(2'd3, v); chk(v == 16'h0000, "R10 status", v, 16'h0000);
    rd(2'd2, v); chk(v == 16'h0000, "R10 ctrl", v, 16'h0000);
    rd(2'd0, v); chk(v == 16'h0000, "R10 empty read", v, 16'h0000);

    // R1 mux layout, R2 scan wrap with software trigger
    wr(2'd1, 16'h0502);
    rd(2'd1, v); chk(v == 16'h0502, "R1 readback", v, 16'h0502);
    chlog.delete();
    repeat (6) begin wr(2'd0, 16'h0); idle(6); end
    chk(chlog.size() == 6, "R2 conv count", 16'(chlog.size()), 16'd6);
    if (chlog.size() == 6) begin
      chk(chlog[3] == 5 && chlog[4] == 2 && chlog[5] == 3, "R2 wrap",
          16'(chlog[4]), 16'd2);
      chk(chlog[0] == 2 && chlog[1] == 3, "R2 first", 16'(chlog[0]), 16'd2);
    end

    // R5 order and empty read
    prev = '0;
    repeat (6) rd(2'd0, prev);
    rd(2'd0, v); chk(v == prev, "R5 empty returns last", v, prev);
    rd(2'd3, v); chk(v[0] == 1'b0, "R5 empty after drain", v, 16'h0);

    // R9 left-justify
    next_val = 12'hABC;
    wr(2'd0, 16'h0); idle(6);
    rd(2'd0, v); chk(v == 16'hABC0, "R9 left justified", v, 16'hABC0);

    // R4 trigger while pending, stray done
    wr(2'd0, 16'h0); wr(2'd0, 16'h0); idle(6);
    rd(2'd0, v); rd(2'd0, v);
    @(posedge clk); #1 spur_done = 1'b1;
    @(posedge clk); #1 spur_done = 1'b0;
    rd(2'd3, v); chk(v == 16'h0000, "R4 stray done ignored", v, 16'h0000);

    // R3 falling, rising, pacer; software ignored when not selected
    wr(2'd2, 16'h0001);
    repeat (3) begin ext = 1'b1; idle(2); #1 ext = 1'b0; idle(8); end
    wr(2'd0, 16'h0); idle(6);
    wr(2'd2, 16'h0002);
    repeat (3) begin #1 ext = 1'b1; idle(8); #1 ext = 1'b0; idle(3); end
    wr(2'd2, 16'h0003);
    repeat (3) begin @(posedge clk); #1 tick = 1'b1; @(posedge clk); #1 tick = 1'b0; idle(8); end
    wr(2'd0, 16'h0); idle(6);
    rd(2'd3, v); chk(v[4] == 1'b0, "R3 soft write ignored", v, 16'h0);
    repeat (12) rd(2'd0, v);

    // R7 / R6 overflow with held pacer
    wr(2'd1, 16'h0700);
    @(posedge clk); #1 tick = 1'b1;
    idle(120);
    #1 tick = 1'b0;
    idle(6);
    rd(2'd3, v); chk((v & 16'h000F) == 16'h000F, "R7 overflow and full", v, 16'h000F);
    wr(2'd3, 16'h0001);
    rd(2'd3, v); chk(v[3] == 1'b0, "R7 overflow cleared", v, 16'h0);
    repeat (17) rd(2'd0, v);

    // R8 differential clamp
    wr(2'd2, 16'h0004);
    wr(2'd1, 16'h2321);
    @(negedge clk); chk(chan_sel == 6'd32, "R8 clamp", {10'd0, chan_sel}, 16'd32);
    repeat (3) begin wr(2'd0, 16'h0); idle(6); end
    wr(2'd2, 16'h0000);
    idle(2);
    repeat (3) begin wr(2'd0, 16'h0); idle(6); end

    // R2 single channel repeat
    wr(2'd1, 16'h0909);
    chlog.delete();
    repeat (3) begin wr(2'd0, 16'h0); idle(6); end
    chk(chlog.size() == 3 && chlog[0] == 9 && chlog[2] == 9, "R2 single channel",
        16'(chlog.size()), 16'd3);
    repeat (8) rd(2'd0, v);

    idle(4);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule